// File: doc/BRIEF.md
# Separable 2-D Wavelet Tile Transformer

This block performs a single-level forward 2-D wavelet decomposition of an 8x8 tile of signed samples. Samples enter one per handshake in raster order (row 0 first, left to right). Two copies of the same 1-D integer lifting core do the work: the horizontal core transforms each row as soon as its eight samples are in, and its results are written into a tile-sized transpose store. When all rows are done, the vertical core transforms every column of that store in place. The results are then streamed out, one coefficient per cycle, grouped by subband.

Each core has two grouped activity enables. One opens the input register bank, which latches a line of operands. The other opens the adder operands one cycle later and latches the results in the output register bank. The controller raises a core's enables only during the cycles in which that core computes. Cycles that only write results into the store, and every cycle belonging to the other pass, leave them low. These enables appear at the ports so that gating cells outside the block can use them.

The 1-D transform is the reversible integer 5/3 lifting pair with mirrored edges. A line of N samples yields N/2 low coefficients followed by N/2 high coefficients.

Top module: `wv2d_tile`

## Requirements
- R1: While reset is held and in the first cycle after it is released, in_ready_o is 1, out_valid_o is 0, busy_o is 0 and all four enables are 0.
- R2: Samples are accepted only when in_valid_i and in_ready_o are both high. After the 8th sample of a row is accepted, in_ready_o stays low for exactly 3 cycles before the next row can start. After the 64th sample it stays low until the last coefficient of the tile is presented.
- R3: For a line x[0..7], high h[i] = x[2i+1] - floor((x[2i]+x[2i+2])/2), with x[8] taken as x[6]. Low l[i] = x[2i] + floor((h[i-1]+h[i]+2)/4), with h[-1] taken as h[0]. Each row is replaced by l[0..3] followed by h[0..3].
- R4: Each column of the row results is transformed with the R3 rule. Rows 0..3 of a column then hold the vertical lows and rows 4..7 hold the vertical highs.
- R5: A tile emits exactly 64 coefficients on consecutive cycles with out_valid_o high. They come in band order 00 = LL, 01 = LH, 10 = HL, 11 = HH, 16 per band, in row-major order within the band. LH is made of columns 0..3 and rows 4..7. HL is made of columns 4..7 and rows 0..3.
- R6: For each row, row_reg_en_o is high for one cycle and row_add_en_o is high in the following cycle. The two are never high together. Each is high exactly 8 cycles per tile.
- R7: The column enables follow the same pattern, 8 cycles each per tile. No row enable is high while a column enable is high. in_ready_o is low whenever a column enable is high.
- R8: busy_o is high from the cycle after the first accepted sample through the cycle of the last coefficient, and low afterwards.
- R9: Values presented with in_valid_i high while in_ready_o is low have no effect on the coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block can take a sample |
| in_data_i | input | DW (8) | Signed input sample |
| out_valid_o | output | 1 | Coefficient valid |
| out_band_o | output | 2 | Subband tag of the coefficient |
| out_data_o | output | CW (12) | Signed coefficient |
| busy_o | output | 1 | A tile is in flight |
| row_reg_en_o | output | 1 | Horizontal core register bank enable |
| row_add_en_o | output | 1 | Horizontal core adder enable |
| col_reg_en_o | output | 1 | Vertical core register bank enable |
| col_add_en_o | output | 1 | Vertical core adder enable |

## Verification
An all-zero tile and flat tiles at both input extremes leave only LL energy. These tiles separate a wrong band tag or a wrong output order from a wrong rounding. A tile whose rows are all identical has zero vertical highs, so the LL and HL values expose the horizontal lifting on its own. A checkerboard and a ramp load the mirrored edges and the high bands. Seeded random tiles, with junk presented while the block refuses input, catch transposition slips, sign-extension errors and samples taken out of turn. These random tiles are compared against a model of the lifting steps kept in the bench.

// File: rtl/wv2d_pkg.sv
package wv2d_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW_FILL, ST_ROW_CALC, ST_XPOSE_WAIT, ST_COL_CALC, ST_DRAIN
  } wv_state_e;

  typedef enum logic [1:0] {
    BAND_LL = 2'b00, BAND_LH = 2'b01, BAND_HL = 2'b10, BAND_HH = 2'b11
  } wv_band_e;

  typedef enum logic [1:0] {PH_LOAD = 2'd0, PH_ADD = 2'd1, PH_STORE = 2'd2} wv_phase_e;
endpackage

// File: rtl/wv_lift_core.sv
module wv_lift_core #(
  parameter int N = 8,
  parameter int W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_en_i,
  input  logic                add_en_i,
  input  logic [N-1:0][W-1:0] x_i,
  output logic [N-1:0][W-1:0] y_o
);
  localparam int H = N / 2;

  logic [N-1:0][W-1:0] in_q, src, out_d, out_q;
  logic signed [W-1:0] ev [H];
  logic signed [W-1:0] od [H];
  logic signed [W-1:0] dv [H];
  logic signed [W-1:0] av [H];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) in_q <= '0;
    else if (reg_en_i) in_q <= x_i;

  // operand isolation: adders see zeros unless enabled
  assign src = add_en_i ? in_q : '0;

  for (genvar i = 0; i < H; i++) begin : g_lift
    localparam int NX = (i == H - 1) ? i : i + 1;
    localparam int PV = (i == 0) ? 0 : i - 1;
    logic signed [W+1:0] esum, dsum;
    assign ev[i] = $signed(src[2*i]);
    assign od[i] = $signed(src[2*i+1]);
    assign esum  = (W+2)'(ev[i]) + (W+2)'(ev[NX]);
    assign dv[i] = W'((W+2)'(od[i]) - (esum >>> 1));
    assign dsum  = (W+2)'(dv[PV]) + (W+2)'(dv[i]) + (W+2)'(2);
    assign av[i] = W'((W+2)'(ev[i]) + (dsum >>> 2));
    assign out_d[i]     = av[i];
    assign out_d[H + i] = dv[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) out_q <= '0;
    else if (add_en_i) out_q <= out_d;

  assign y_o = out_q;
endmodule

// File: rtl/wv_xpose_buf.sv
module wv_xpose_buf #(
  parameter int N = 8,
  parameter int W = 12,
  localparam int LW = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                row_wr_i,
  input  logic                col_wr_i,
  input  logic [LW-1:0]       line_i,
  input  logic [N-1:0][W-1:0] wvec_i,
  output logic [N-1:0][W-1:0] rcol_o,
  input  logic [LW-1:0]       rd_r_i,
  input  logic [LW-1:0]       rd_c_i,
  output logic [W-1:0]        rd_o
);
  logic [N-1:0][N-1:0][W-1:0] mem_q;

  for (genvar r = 0; r < N; r++) begin : g_r
    for (genvar c = 0; c < N; c++) begin : g_c
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) mem_q[r][c] <= '0;
        else if (row_wr_i && line_i == LW'(r)) mem_q[r][c] <= wvec_i[c];
        else if (col_wr_i && line_i == LW'(c)) mem_q[r][c] <= wvec_i[r];
    end
    assign rcol_o[r] = mem_q[r][line_i];
  end

  assign rd_o = mem_q[rd_r_i][rd_c_i];
endmodule

// File: rtl/wv_ctrl.sv
module wv_ctrl
  import wv2d_pkg::*;
#(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_fire_i,
  output logic            in_ready_o,
  output logic [LW-1:0]   fill_idx_o,
  output logic [LW-1:0]   line_idx_o,
  output logic            row_reg_en_o,
  output logic            row_add_en_o,
  output logic            row_wr_o,
  output logic            col_reg_en_o,
  output logic            col_add_en_o,
  output logic            col_wr_o,
  output logic            drain_vld_o,
  output logic [2*LW-1:0] drain_idx_o,
  output wv_state_e       state_o
);
  wv_state_e       state_q, state_d;
  wv_phase_e       ph_q, ph_d;
  logic [LW-1:0]   fill_q, fill_d, line_q, line_d;
  logic [2*LW-1:0] didx_q, didx_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= PH_LOAD;
      fill_q  <= '0;
      line_q  <= '0;
      didx_q  <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      fill_q  <= fill_d;
      line_q  <= line_d;
      didx_q  <= didx_d;
    end

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    fill_d  = fill_q;
    line_d  = line_q;
    didx_d  = didx_q;
    row_reg_en_o = 1'b0;
    row_add_en_o = 1'b0;
    row_wr_o     = 1'b0;
    col_reg_en_o = 1'b0;
    col_add_en_o = 1'b0;
    col_wr_o     = 1'b0;
    drain_vld_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (in_fire_i) begin
        fill_d  = LW'(1);
        line_d  = '0;
        state_d = ST_ROW_FILL;
      end
      ST_ROW_FILL: if (in_fire_i) begin
        if (fill_q == LW'(N - 1)) begin
          fill_d  = '0;
          ph_d    = PH_LOAD;
          state_d = ST_ROW_CALC;
        end else fill_d = fill_q + LW'(1);
      end
      ST_ROW_CALC: begin
        unique case (ph_q)
          PH_LOAD: begin row_reg_en_o = 1'b1; ph_d = PH_ADD;   end
          PH_ADD:  begin row_add_en_o = 1'b1; ph_d = PH_STORE; end
          default: begin
            row_wr_o = 1'b1;
            ph_d     = PH_LOAD;
            if (line_q == LW'(N - 1)) begin
              line_d  = '0;
              state_d = ST_XPOSE_WAIT;
            end else begin
              line_d  = line_q + LW'(1);
              state_d = ST_ROW_FILL;
            end
          end
        endcase
      end
      ST_XPOSE_WAIT: begin
        ph_d    = PH_LOAD;
        state_d = ST_COL_CALC;
      end
      ST_COL_CALC: begin
        unique case (ph_q)
          PH_LOAD: begin col_reg_en_o = 1'b1; ph_d = PH_ADD;   end
          PH_ADD:  begin col_add_en_o = 1'b1; ph_d = PH_STORE; end
          default: begin
            col_wr_o = 1'b1;
            ph_d     = PH_LOAD;
            if (line_q == LW'(N - 1)) begin
              line_d  = '0;
              didx_d  = '0;
              state_d = ST_DRAIN;
            end else line_d = line_q + LW'(1);
          end
        endcase
      end
      ST_DRAIN: begin
        drain_vld_o = 1'b1;
        didx_d      = didx_q + 1'b1;
        if (didx_q == '1) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign in_ready_o  = (state_q == ST_IDLE) || (state_q == ST_ROW_FILL);
  assign fill_idx_o  = fill_q;
  assign line_idx_o  = line_q;
  assign drain_idx_o = didx_q;
  assign state_o     = state_q;
endmodule

// File: rtl/wv2d_tile.sv
module wv2d_tile
  import wv2d_pkg::*;
#(
  parameter int DW = 8,
  parameter int N  = 8,
  parameter int CW = DW + 4,
  localparam int LW = $clog2(N),
  localparam int HW = LW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  output logic [1:0]    out_band_o,
  output logic [CW-1:0] out_data_o,
  output logic          busy_o,
  output logic          row_reg_en_o,
  output logic          row_add_en_o,
  output logic          col_reg_en_o,
  output logic          col_add_en_o
);
  logic                 in_fire, row_wr, col_wr, drain_vld;
  logic [LW-1:0]        fill_idx, line_idx, rd_r, rd_c;
  logic [2*LW-1:0]      drain_idx;
  logic [1:0]           drain_band;
  wv_state_e            state;
  logic [N-1:0][CW-1:0] row_q, row_res, col_src, col_res, wvec;
  logic [CW-1:0]        rd_data, out_data_q;
  logic                 out_valid_q;
  logic [1:0]           out_band_q;

  assign in_fire = in_valid_i && in_ready_o;

  wv_ctrl #(.N(N)) u_ctrl (
    .clk_i, .rst_ni,
    .in_fire_i    (in_fire),
    .in_ready_o   (in_ready_o),
    .fill_idx_o   (fill_idx),
    .line_idx_o   (line_idx),
    .row_reg_en_o (row_reg_en_o),
    .row_add_en_o (row_add_en_o),
    .row_wr_o     (row_wr),
    .col_reg_en_o (col_reg_en_o),
    .col_add_en_o (col_add_en_o),
    .col_wr_o     (col_wr),
    .drain_vld_o  (drain_vld),
    .drain_idx_o  (drain_idx),
    .state_o      (state)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) row_q <= '0;
    else if (in_fire) row_q[fill_idx] <= {{(CW-DW){in_data_i[DW-1]}}, in_data_i};

  wv_lift_core #(.N(N), .W(CW)) u_row_core (
    .clk_i, .rst_ni,
    .reg_en_i (row_reg_en_o),
    .add_en_i (row_add_en_o),
    .x_i      (row_q),
    .y_o      (row_res)
  );

  wv_lift_core #(.N(N), .W(CW)) u_col_core (
    .clk_i, .rst_ni,
    .reg_en_i (col_reg_en_o),
    .add_en_i (col_add_en_o),
    .x_i      (col_src),
    .y_o      (col_res)
  );

  assign wvec       = col_wr ? col_res : row_res;
  assign drain_band = drain_idx[2*LW-1 -: 2];
  // band bit 0 selects vertical high rows, bit 1 horizontal high columns
  assign rd_r = {drain_band[0], drain_idx[2*HW-1 -: HW]};
  assign rd_c = {drain_band[1], drain_idx[HW-1:0]};

  wv_xpose_buf #(.N(N), .W(CW)) u_buf (
    .clk_i, .rst_ni,
    .row_wr_i (row_wr),
    .col_wr_i (col_wr),
    .line_i   (line_idx),
    .wvec_i   (wvec),
    .rcol_o   (col_src),
    .rd_r_i   (rd_r),
    .rd_c_i   (rd_c),
    .rd_o     (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_band_q  <= '0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= drain_vld;
      if (drain_vld) begin
        out_band_q <= drain_band;
        out_data_q <= rd_data;
      end
    end

  assign out_valid_o = out_valid_q;
  assign out_band_o  = out_band_q;
  assign out_data_o  = out_data_q;
  assign busy_o      = (state != ST_IDLE) || out_valid_q;
endmodule

// File: rtl/wv2d_tile_chk.sv
module wv2d_tile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic [1:0] out_band_o,
  input logic       busy_o,
  input logic       row_reg_en_o,
  input logic       row_add_en_o,
  input logic       col_reg_en_o,
  input logic       col_add_en_o
);
  // R6
  row_add_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_reg_en_o |=> row_add_en_o);
  // R6
  row_add_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_add_en_o |-> $past(row_reg_en_o));
  // R6
  row_en_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(row_reg_en_o && row_add_en_o));
  // R7
  col_add_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_reg_en_o |=> col_add_en_o);
  // R7
  stage_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((row_reg_en_o || row_add_en_o) && (col_reg_en_o || col_add_en_o)));
  // R7
  col_blocks_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_reg_en_o || col_add_en_o) |-> !in_ready_o);
  // R8
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> busy_o);
  // R5
  band_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o)) |-> (out_band_o >= $past(out_band_o)));
endmodule

bind wv2d_tile wv2d_tile_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_band_o   (out_band_o),
  .busy_o       (busy_o),
  .row_reg_en_o (row_reg_en_o),
  .row_add_en_o (row_add_en_o),
  .col_reg_en_o (col_reg_en_o),
  .col_add_en_o (col_add_en_o)
);

// File: tb/wv2d_tile_tb.sv
module wv2d_tile_tb;
  localparam int DW = 8;
  localparam int N  = 8;
  localparam int CW = DW + 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid, busy;
  logic          rre, rae, cre, cae;
  logic [1:0]    out_band;
  logic [CW-1:0] out_data;

  always #4 clk = ~clk;

  wv2d_tile #(.DW(DW), .N(N), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_band_o(out_band), .out_data_o(out_data),
    .busy_o(busy),
    .row_reg_en_o(rre), .row_add_en_o(rae), .col_reg_en_o(cre), .col_add_en_o(cae)
  );

  int checks = 0, errors = 0, cycles = 0;
  int tile [64];
  int expv [64];
  int got  [64];
  int gotb [64];
  int n_got, rr_cnt, ra_cnt, cr_cnt, ca_cnt, row_err, col_err, busy_err, gap_err;
  bit mon_on = 0, prev_rre, prev_cre, started;

  task automatic check(bit ok, string req, string what, int act, int expd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expd);
    end
  endtask

  function automatic void lift8(input int x[8], output int y[8]);
    int d[4];
    for (int i = 0; i < 4; i++)
      d[i] = x[2*i+1] - ((x[2*i] + x[(i == 3) ? 6 : 2*i+2]) >>> 1);
    for (int i = 0; i < 4; i++) begin
      y[i]   = x[2*i] + ((d[(i == 0) ? 0 : i-1] + d[i] + 2) >>> 2);
      y[4+i] = d[i];
    end
  endfunction

  task automatic compute_expected();
    int rr [8][8];
    int cc [8][8];
    int v[8], w[8];
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) v[c] = tile[r*8+c];
      lift8(v, w);
      for (int c = 0; c < 8; c++) rr[r][c] = w[c];
    end
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) v[r] = rr[r][c];
      lift8(v, w);
      for (int r = 0; r < 8; r++) cc[r][c] = w[r];
    end
    for (int i = 0; i < 64; i++) begin
      int b = i / 16, k = i % 16;
      expv[i] = cc[(k >> 2) + ((b & 1) ? 4 : 0)][(k & 3) + ((b & 2) ? 4 : 0)];
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (mon_on) begin
      if (out_valid) begin
        if (n_got < 64) begin
          got[n_got]  = int'($signed(out_data));
          gotb[n_got] = int'(out_band);
        end
        n_got++;
        started = 1;
        if (!busy) busy_err++;
      end else if (started && n_got < 64) gap_err++;
      rr_cnt += int'(rre); ra_cnt += int'(rae);
      cr_cnt += int'(cre); ca_cnt += int'(cae);
      if ((rae && !prev_rre) || (rre && rae)) row_err++;
      if ((cae && !prev_cre) || (cre && cae)) col_err++;
      if ((rre || rae) && (cre || cae)) col_err++;
      if ((cre || cae) && in_ready) col_err++;
      prev_rre = rre;
      prev_cre = cre;
    end
  end

  task automatic run_tile(string name, string vtag);
    int k = 0, gap = 0, wait_c = 0, bad = 0;
    n_got = 0; rr_cnt = 0; ra_cnt = 0; cr_cnt = 0; ca_cnt = 0;
    row_err = 0; col_err = 0; busy_err = 0; gap_err = 0;
    prev_rre = 0; prev_cre = 0; started = 0;
    compute_expected();
    mon_on = 1;
    while (k < 64) begin
      @(negedge clk);
      if (in_ready) begin
        in_valid = 1'b1;
        in_data  = DW'(tile[k]);
        k++;
      end else begin
        in_valid = 1'b1;          // junk while refused (R9)
        in_data  = DW'($urandom);
        if (k == 8) gap++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (n_got < 64 && wait_c < 400) begin
      @(negedge clk);
      wait_c++;
    end
    @(negedge clk);
    mon_on = 0;
    check(gap == 3, "R2", {name, " ready gap after first row"}, gap, 3);
    check(n_got == 64, "R5", {name, " coefficient count"}, n_got, 64);
    check(gap_err == 0, "R5", {name, " valid gaps"}, gap_err, 0);
    for (int i = 0; i < 64 && i < n_got; i++) begin
      if (gotb[i] != i / 16) bad++;
      if (got[i] != expv[i]) begin
        check(0, vtag, $sformatf("%s coef %0d", name, i), got[i], expv[i]);
      end
    end
    check(bad == 0, "R5", {name, " band order mismatches"}, bad, 0);
    check(1, vtag, {name, " coefficient values"}, 0, 0);
    check(rr_cnt == 8 && ra_cnt == 8, "R6", {name, " row enable cycles"}, rr_cnt * 100 + ra_cnt, 808);
    check(row_err == 0, "R6", {name, " row enable order"}, row_err, 0);
    check(cr_cnt == 8 && ca_cnt == 8, "R7", {name, " col enable cycles"}, cr_cnt * 100 + ca_cnt, 808);
    check(col_err == 0, "R7", {name, " col enable exclusion"}, col_err, 0);
    check(busy_err == 0 && !busy, "R8", {name, " busy span"}, busy_err * 10 + int'(busy), 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready && !out_valid && !busy, "R1", "in reset ready/valid/busy",
          {int'(in_ready), int'(out_valid), int'(busy)}, 4);
    check(!(rre || rae || cre || cae), "R1", "in reset enables", int'({rre, rae, cre, cae}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid && !busy, "R1", "after release",
          {int'(in_ready), int'(out_valid), int'(busy)}, 4);
    check(!(rre || rae || cre || cae), "R1", "after release enables", int'({rre, rae, cre, cae}), 0);

    for (int i = 0; i < 64; i++) tile[i] = 0;
    run_tile("zero", "R4");
    for (int i = 0; i < 64; i++) tile[i] = 127;
    run_tile("flat_max", "R4");
    for (int i = 0; i < 64; i++) tile[i] = -128;
    run_tile("flat_min", "R4");
    for (int i = 0; i < 64; i++) tile[i] = (i % 8) * 29 - 100 + ((i % 3) * 7);
    for (int i = 8; i < 64; i++) tile[i] = tile[i % 8];
    run_tile("same_rows", "R3");
    for (int i = 0; i < 64; i++) tile[i] = (((i / 8) + (i % 8)) % 2) ? 127 : -128;
    run_tile("checker", "R4");
    for (int i = 0; i < 64; i++) tile[i] = i * 4 - 128;
    run_tile("ramp", "R4");
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < 64; i++) tile[i] = int'($urandom % 256) - 128;
      run_tile($sformatf("rand%0d", t), "R9");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule